// File: doc/BRIEF.md
# Event Status and Interrupt Collector

This block gathers the single-cycle event pulses coming out of an Ethernet MAC datapath and turns them into latched status that a host can inspect through a small synchronous register port. It handles four kinds of event: a frame was received, a frame was sent, the receive buffer overflowed, and the overflow statistic itself rolled over. Each of these events latches into a status register. The host clears a status bit by writing 1 to it. A separate mask register decides which latched bits drive the single interrupt output. The output polarity is chosen at build time.

A statistics register counts receive-overflow events in a narrow counter with a sticky rollover flag. Reading that register returns the current value and clears it. Completion flags for two transmit buffer slots sit in a network status register. Each of those flags clears either on a read of that register or on a write of 1. The register port is a plain strobe interface: read data is a combinational function of the address and the current state, and the side effects of a read or a write take place at the next rising clock edge.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset, every status bit, the mask, the overflow count, its rollover flag and both transmit-slot flags are 0, and the interrupt output is at its inactive level.
- R2: A pulse on ev_rx_done, ev_tx_done or ev_rx_ovf sets status bit 0, bit 1 or bit 2 respectively (status register at address FEh) at the next clock edge. The bit stays set until the host clears it.
- R3: A write to FEh clears each status bit whose write-data bit is 1 and leaves alone each bit whose write-data bit is 0. Reading FEh returns the status bits in bits 3:0 and zeros above them.
- R4: If an event and a write-1 clear hit the same status or transmit-slot bit in the same cycle, the bit ends up set.
- R5: The mask register at FFh is fully readable and writable and resets to 00h.
- R6: The interrupt is active exactly when some status bit 3:0 is set and its mask bit is set. With the default polarity the active level is high; the IRQ_LOW parameter makes it active low.
- R7: Address 07h reads the overflow count in bits 6:0 and the rollover flag in bit 7. Each ev_rx_ovf pulse adds one to the count.
- R8: A pulse that arrives when the count is 127 wraps the count to 0, sets the rollover flag and sets status bit 3 at the same edge.
- R9: Reading 07h clears both the count and the rollover flag. An overflow pulse in the same cycle as that read is not lost: the count becomes 1.
- R10: Pulses on ev_tx1_done and ev_tx2_done set bits 2 and 3 of the network status register at 01h. A read of 01h clears both bits. A write of 1 to either bit clears that bit.
- R11: Writes to 07h and to any address without a register change no state. Reads of an address without a register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_done | input | 1 | Frame-received event pulse |
| ev_tx_done | input | 1 | Frame-sent event pulse |
| ev_rx_ovf | input | 1 | Receive-buffer overflow event pulse |
| ev_tx1_done | input | 1 | Transmit slot 1 complete pulse |
| ev_tx2_done | input | 1 | Transmit slot 2 complete pulse |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (clear side effects occur at the edge) |
| host_addr | input | 8 | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data for host_addr |
| irq | output | 1 | Interrupt output |

## Verification
Random cycles fire the five event pulses at independent rates while reads and writes land mostly on the four mapped addresses. This shows whether each status bit latches, clears and gates the interrupt separately from its neighbours. A run of 128 consecutive overflow pulses with no reads tests the count increment, the wrap, the rollover flag and the status bit 3 link, which random traffic seldom reaches. Directed cycles place an event and its own clear in the same cycle, and an overflow pulse on the same cycle as a counter read. These tell a correct set-wins and lost-event policy apart from a clear-wins one. Writes aimed at the read-clear counter and at unmapped addresses show whether any state leaks through a path that should not exist.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   localparam int ADDR_W = 8;
   typedef logic [ADDR_W-1:0] addr_t;

   // Register addresses
   localparam addr_t A_NSTAT = 8'h01;
   localparam addr_t A_ROVF  = 8'h07;
   localparam addr_t A_STAT  = 8'hFE;
   localparam addr_t A_MASK  = 8'hFF;

   // Status bit positions
   localparam int ST_RX    = 0;
   localparam int ST_TX    = 1;
   localparam int ST_ROV   = 2;
   localparam int ST_CNTOV = 3;
   localparam int ST_N     = 4;

   // Network status: transmit slot flags
   localparam int NS_TX1 = 2;
   localparam int NS_TX2 = 3;
   localparam int NS_N   = 2;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
   parameter int N         = 4,
   parameter bit CLR_ON_RD = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] wr_clr_i,
   input  logic         rd_clr_i,
   output logic [N-1:0] q_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("evt_flag_bank: N must be at least 1");
      end
   endgenerate

   logic rd_clr_en;
   assign rd_clr_en = rd_clr_i & CLR_ON_RD;

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic clr;
      assign clr = wr_clr_i[i] | rd_clr_en;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_o[i] <= 1'b0;
         else        q_o[i] <= set_i[i] | (q_o[i] & ~clr);
      end
   end
endmodule

// File: rtl/evt_ovf_counter.sv
module evt_ovf_counter #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             rd_clr_i,
   output logic [CNT_W-1:0] count_o,
   output logic             flag_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("evt_ovf_counter: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] count_d;
   logic             flag_d;

   always_comb begin
      base    = rd_clr_i ? '0 : count_o;
      wrap_o  = inc_i & ~rd_clr_i & (count_o == CNT_MAX);
      count_d = inc_i ? base + CNT_ONE : base;
      flag_d  = (flag_o & ~rd_clr_i) | wrap_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_o <= '0;
         flag_o  <= 1'b0;
      end else begin
         count_o <= count_d;
         flag_o  <= flag_d;
      end
   end
endmodule

// File: rtl/evt_irq_drive.sv
module evt_irq_drive #(
   parameter int N       = 4,
   parameter bit IRQ_LOW = 1'b0
) (
   input  logic [N-1:0] stat_i,
   input  logic [N-1:0] mask_i,
   output logic         irq_o
);
   logic pending;
   assign pending = |(stat_i & mask_i);

   generate
      if (IRQ_LOW) begin : g_active_low
         assign irq_o = ~pending;
      end else begin : g_active_high
         assign irq_o = pending;
      end
   endgenerate
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
   import evt_irq_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 7,
   parameter bit IRQ_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_rx_done,
   input  logic              ev_tx_done,
   input  logic              ev_rx_ovf,
   input  logic              ev_tx1_done,
   input  logic              ev_tx2_done,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              irq
);
   generate
      if (CNT_W + 1 > DATA_W) begin : g_bad_cnt
         $error("evt_irq_hub: count plus flag must fit in DATA_W");
      end
      if (ST_N > DATA_W || NS_TX2 >= DATA_W) begin : g_bad_data
         $error("evt_irq_hub: DATA_W too narrow for status fields");
      end
   endgenerate

   // Address decode
   logic hit_stat, hit_mask, hit_rovf, hit_nstat;
   assign hit_stat  = (host_addr == A_STAT);
   assign hit_mask  = (host_addr == A_MASK);
   assign hit_rovf  = (host_addr == A_ROVF);
   assign hit_nstat = (host_addr == A_NSTAT);

   // Overflow counter
   logic [CNT_W-1:0] roc_count;
   logic             roc_flag;
   logic             roc_wrap;

   evt_ovf_counter #(.CNT_W(CNT_W)) u_roc (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (ev_rx_ovf),
      .rd_clr_i (host_rd & hit_rovf),
      .count_o  (roc_count),
      .flag_o   (roc_flag),
      .wrap_o   (roc_wrap)
   );

   // Interrupt status bank (write-1-to-clear only)
   logic [ST_N-1:0] stat_q;
   logic [ST_N-1:0] stat_set;
   logic [ST_N-1:0] stat_wclr;

   always_comb begin
      stat_set           = '0;
      stat_set[ST_RX]    = ev_rx_done;
      stat_set[ST_TX]    = ev_tx_done;
      stat_set[ST_ROV]   = ev_rx_ovf;
      stat_set[ST_CNTOV] = roc_wrap;
      stat_wclr          = (host_wr && hit_stat) ? host_wdata[ST_N-1:0] : '0;
   end

   evt_flag_bank #(.N(ST_N), .CLR_ON_RD(1'b0)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (stat_set),
      .wr_clr_i (stat_wclr),
      .rd_clr_i (1'b0),
      .q_o      (stat_q)
   );

   // Transmit slot flags (read-clear and write-1-to-clear)
   logic [NS_N-1:0] ns_q;
   logic [NS_N-1:0] ns_wclr;

   assign ns_wclr = (host_wr && hit_nstat) ? host_wdata[NS_TX2:NS_TX1] : '0;

   evt_flag_bank #(.N(NS_N), .CLR_ON_RD(1'b1)) u_nstat (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    ({ev_tx2_done, ev_tx1_done}),
      .wr_clr_i (ns_wclr),
      .rd_clr_i (host_rd & hit_nstat),
      .q_o      (ns_q)
   );

   // Mask register
   logic [DATA_W-1:0] mask_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   mask_q <= '0;
      else if (host_wr && hit_mask) mask_q <= host_wdata;
   end

   // Interrupt output
   evt_irq_drive #(.N(ST_N), .IRQ_LOW(IRQ_LOW)) u_irq (
      .stat_i (stat_q),
      .mask_i (mask_q[ST_N-1:0]),
      .irq_o  (irq)
   );

   // Read mux
   always_comb begin
      host_rdata = '0;
      if (hit_stat) begin
         host_rdata[ST_N-1:0] = stat_q;
      end else if (hit_mask) begin
         host_rdata = mask_q;
      end else if (hit_rovf) begin
         host_rdata[CNT_W-1:0] = roc_count;
         host_rdata[CNT_W]     = roc_flag;
      end else if (hit_nstat) begin
         host_rdata[NS_TX2:NS_TX1] = ns_q;
      end
   end
endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk
   import evt_irq_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 7,
   parameter bit IRQ_LOW = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_rx_done,
   input logic              ev_tx_done,
   input logic              ev_rx_ovf,
   input logic              host_wr,
   input logic              host_rd,
   input logic [ADDR_W-1:0] host_addr,
   input logic [DATA_W-1:0] host_wdata,
   input logic              irq,
   input logic [ST_N-1:0]   stat_q,
   input logic [DATA_W-1:0] mask_q,
   input logic [CNT_W-1:0]  roc_count,
   input logic              roc_flag
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic rd_rovf, wr_stat;
   assign rd_rovf = host_rd && (host_addr == A_ROVF);
   assign wr_stat = host_wr && (host_addr == A_STAT);

   // R2
   p_rx_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rx_done |=> stat_q[ST_RX]);

   // R3
   p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && host_wdata[ST_ROV] && !ev_rx_ovf) |=> !stat_q[ST_ROV]);

   // R4
   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && host_wdata[ST_TX] && ev_tx_done) |=> stat_q[ST_TX]);

   // R6
   p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[ST_N-1:0] == '0) |-> (irq == IRQ_LOW));

   p_unmasked_fires_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[ST_RX] && mask_q[ST_RX]) |-> (irq != IRQ_LOW));

   // R7
   p_count_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rx_ovf && !rd_rovf && roc_count != CMAX)
      |=> (roc_count == CNT_W'($past(roc_count) + 1'b1)));

   // R8
   p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rx_ovf && !rd_rovf && roc_count == CMAX)
      |=> (roc_count == '0 && roc_flag && stat_q[ST_CNTOV]));

   // R9
   p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rovf && !ev_rx_ovf) |=> (roc_count == '0 && !roc_flag));
endmodule

bind evt_irq_hub evt_irq_hub_chk #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W),
   .IRQ_LOW(IRQ_LOW)
) u_evt_irq_hub_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ev_rx_done (ev_rx_done),
   .ev_tx_done (ev_tx_done),
   .ev_rx_ovf  (ev_rx_ovf),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .irq        (irq),
   .stat_q     (stat_q),
   .mask_q     (mask_q),
   .roc_count  (roc_count),
   .roc_flag   (roc_flag)
);

// File: tb/evt_irq_hub_bench.sv
module evt_irq_hub_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_rx_done = 0, ev_tx_done = 0, ev_rx_ovf = 0;
   logic       ev_tx1_done = 0, ev_tx2_done = 0;
   logic       host_wr = 0, host_rd = 0;
   logic [7:0] host_addr = 8'h00;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic       irq;

   int checks = 0;
   int errors = 0;

   // Reference model state
   logic [3:0] m_stat = '0;
   logic [7:0] m_mask = '0;
   logic [6:0] m_cnt  = '0;
   logic       m_flag = 1'b0;
   logic       m_tx1  = 1'b0;
   logic       m_tx2  = 1'b0;

   evt_irq_hub u_evt_irq_hub (
      .clk(clk), .rst_n(rst_n),
      .ev_rx_done(ev_rx_done), .ev_tx_done(ev_tx_done), .ev_rx_ovf(ev_rx_ovf),
      .ev_tx1_done(ev_tx1_done), .ev_tx2_done(ev_tx2_done),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
   );

   always #10 clk = ~clk;

   function automatic logic [7:0] exp_rdata(input logic [7:0] a);
      case (a)
         8'hFE:   return {4'b0, m_stat};
         8'hFF:   return m_mask;
         8'h07:   return {m_flag, m_cnt};
         8'h01:   return {4'b0, m_tx2, m_tx1, 2'b0};
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic exp_irq();
      return |(m_stat & m_mask[3:0]);
   endfunction

   function automatic string addr_tag(input logic [7:0] a);
      case (a)
         8'hFE:   return "R3";
         8'hFF:   return "R5";
         8'h07:   return "R7";
         8'h01:   return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, expv, $time);
      end
   endtask

   // One bus cycle: drive at falling edge, check before rising edge, update model after it.
   task automatic step(input logic rx, input logic tx, input logic ov,
                       input logic t1, input logic t2,
                       input logic wr, input logic rd,
                       input logic [7:0] a, input logic [7:0] wd, input string tag);
      logic rd07, wrap;
      logic [6:0] base;
      logic [1:0] ns_clr;
      logic [3:0] st_clr;
      @(negedge clk);
      ev_rx_done = rx; ev_tx_done = tx; ev_rx_ovf = ov;
      ev_tx1_done = t1; ev_tx2_done = t2;
      host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
      #2;
      check(irq == exp_irq(), "R6 irq", {7'b0, irq}, {7'b0, exp_irq()});
      if (rd) check(host_rdata == exp_rdata(a), tag, host_rdata, exp_rdata(a));
      @(posedge clk);
      rd07   = rd && (a == 8'h07);
      base   = rd07 ? 7'd0 : m_cnt;
      wrap   = ov && (base == 7'h7F);
      m_flag = (rd07 ? 1'b0 : m_flag) | wrap;
      m_cnt  = ov ? base + 7'd1 : base;
      st_clr = (wr && a == 8'hFE) ? wd[3:0] : 4'b0;
      m_stat = {wrap, ov, tx, rx} | (m_stat & ~st_clr);
      if (wr && a == 8'hFF) m_mask = wd;
      ns_clr = (rd && a == 8'h01) ? 2'b11 : ((wr && a == 8'h01) ? wd[3:2] : 2'b00);
      m_tx1  = t1 | (m_tx1 & ~ns_clr[0]);
      m_tx2  = t2 | (m_tx2 & ~ns_clr[1]);
      #1;
   endtask

   task automatic rd_reg(input logic [7:0] a, input string tag);
      step(0, 0, 0, 0, 0, 0, 1, a, 8'h00, tag);
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      step(0, 0, 0, 0, 0, 1, 0, a, d, "R11");
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] pick;
      void'($urandom(32'h1F2E3D4C));
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;

      // R1: reset state
      #1;
      check(irq == 1'b0, "R1 irq", {7'b0, irq}, 8'h00);
      rd_reg(8'hFE, "R1 status");
      rd_reg(8'hFF, "R1 mask");
      rd_reg(8'h07, "R1 counter");
      rd_reg(8'h01, "R1 netstat");

      // R2, R5, R6: events latch and raise irq once unmasked
      step(1, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R2");
      rd_reg(8'hFE, "R2 rx latched");
      wr_reg(8'hFF, 8'h0F);
      rd_reg(8'hFF, "R5 mask readback");
      check(irq == 1'b1, "R6 irq active", {7'b0, irq}, 8'h01);
      step(0, 1, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R2");
      rd_reg(8'hFE, "R2 tx latched");

      // R3: partial write-1 clear
      wr_reg(8'hFE, 8'h01);
      rd_reg(8'hFE, "R3 partial clear");
      // R4: set wins against a same-cycle clear
      step(0, 1, 0, 0, 0, 1, 0, 8'hFE, 8'h02, "R4");
      rd_reg(8'hFE, "R4 set wins");
      wr_reg(8'hFE, 8'h0F);
      rd_reg(8'hFE, "R3 all clear");

      // R7, R8: 128 overflow pulses wrap the counter
      for (int i = 0; i < 127; i++) step(0, 0, 1, 0, 0, 0, 0, 8'h00, 8'h00, "R7");
      step(0, 0, 0, 0, 0, 0, 1, 8'hFE, 8'h00, "R7 status before wrap");
      rd_reg(8'hFF, "R5");
      step(0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R7");
      // count is 127 here; peek via address 07h without a read strobe is not possible, so wrap
      step(0, 0, 1, 0, 0, 0, 0, 8'h00, 8'h00, "R8");
      rd_reg(8'hFE, "R8 status bit3");
      // R11: write to counter ignored
      wr_reg(8'h07, 8'h55);
      wr_reg(8'h42, 8'hFF);
      rd_reg(8'h42, "R11 unmapped read");
      rd_reg(8'h07, "R8 wrapped value");
      rd_reg(8'h07, "R9 cleared by read");

      // R9: overflow during read is kept
      step(0, 0, 1, 0, 0, 0, 0, 8'h00, 8'h00, "R9");
      step(0, 0, 1, 0, 0, 0, 1, 8'h07, 8'h00, "R9 read with event");
      rd_reg(8'h07, "R9 event kept");

      // R10: transmit slot flags
      step(0, 0, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R10");
      wr_reg(8'h01, 8'h04);
      rd_reg(8'h01, "R10 w1c slot1");
      rd_reg(8'h01, "R10 read cleared");
      step(0, 0, 0, 1, 0, 1, 0, 8'h01, 8'h04, "R4");
      rd_reg(8'h01, "R4 slot set wins");
      step(0, 0, 0, 0, 1, 0, 1, 8'h01, 8'h00, "R10 read with event");
      rd_reg(8'h01, "R10 slot2 kept");
      wr_reg(8'hFE, 8'h0F);

      // Random traffic
      for (int i = 0; i < 4000; i++) begin
         logic wr, rd;
         logic [7:0] a;
         pick = 8'($urandom_range(0, 9));
         case (pick)
            0, 1, 2: a = 8'hFE;
            3, 4:    a = 8'h07;
            5, 6:    a = 8'h01;
            7, 8:    a = 8'hFF;
            default: a = 8'($urandom);
         endcase
         wr = ($urandom_range(0, 3) == 0);
         rd = !wr && ($urandom_range(0, 2) == 0);
         step(($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
              ($urandom_range(0, 3) == 0), ($urandom_range(0, 9) == 0),
              ($urandom_range(0, 9) == 0), wr, rd, a, 8'($urandom), addr_tag(a));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule